// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

This block watches the digital code of one temperature sensor channel and raises an interrupt when that code crosses any of three programmable thresholds. Each threshold produces two separate events: one when the code climbs from below the threshold to at or above it, and one when the code drops from at or above it to below it. The sensor side delivers a 12-bit code with a one-cycle valid strobe. The code held from the previous strobe is the reference for crossing detection, and it is zero after reset.

Software programs the thresholds and two 6-bit gates through a 32-bit register port with single-cycle writes and combinational reads. The enable gate decides which events are recorded in the status register. The mask gate works as an unmask and decides which recorded events drive the interrupt line. A typical setup uses the falling event of threshold 1 as a low trip and the rising event of threshold 2 as a high trip. Software acknowledges events by writing the status register. A 6-bit control register is provided for software configuration values and has no effect on the event logic.

Top module: `tsense_alarm_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Register map (byte offsets): status 0x04, mask 0x08, control 0x0C, enable 0x10, threshold 1/2/3 at 0x14/0x18/0x1C, sensor code 0x28. Mask, enable, control and status read back bits 5:0 and thresholds read back bits 11:0, with the upper bits zero. Unmapped offsets read zero.
- R3: When `code_vld_i` is high, `code_i` is captured and then read back in bits 11:0 at offset 0x28. The captured code holds while the strobe is low.
- R4: The rising event of threshold k (status bit k-1, bits 0..2) is set when the previous code is below the threshold and the new code is greater than or equal to it.
- R5: The falling event of threshold k (status bit k+2, bits 3..5) is set when the previous code is greater than or equal to the threshold and the new code is below it.
- R6: A sample that stays on the same side of every threshold sets no event. A change on `code_i` without the strobe sets no event.
- R7: An event is recorded in status only if its enable bit (same bit position) is set.
- R8: `irq_o` is high exactly when some status bit and the mask bit in the same position are both set.
- R9: A write to status clears every bit whose written value is 0 and keeps the bits written as 1. Writing zero clears all bits, and a write never sets a bit.
- R10: An event that arrives in the same cycle as a clearing status write stays pending.
- R11: One sample that crosses several thresholds sets all the matching event bits at once.
- R12: Status and `irq_o` change at the first clock edge that samples the strobe, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| code_vld_i | input | 1 | Sensor code valid strobe |
| code_i | input | 12 | Sensor code |
| irq_o | output | 1 | Interrupt request |

## Verification
A register write takes effect at the next rising edge. A sampled code updates the captured code and the status bits at the edge that sees the strobe. `irq_o` follows status in that same cycle because it is a pure AND-OR of registers, and reads are combinational. The bench therefore drives every input on the falling edge and checks on the following falling edge, after exactly one rising edge. For the timing requirement it also checks just after driving the strobe, before the edge, that status and `irq_o` have not yet moved.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam logic [7:0] OFS_STATUS   = 8'h04;
  localparam logic [7:0] OFS_MASK     = 8'h08;
  localparam logic [7:0] OFS_CTRL     = 8'h0C;
  localparam logic [7:0] OFS_ENABLE   = 8'h10;
  localparam logic [7:0] OFS_THR_BASE = 8'h14;
  localparam logic [7:0] OFS_CODE     = 8'h28;

  function automatic logic [7:0] thr_ofs(input int idx);
    return OFS_THR_BASE + 8'(idx * 4);
  endfunction
endpackage

// File: rtl/tsa_cross_detect.sv
module tsa_cross_detect #(
  parameter int CODE_W  = 12,
  parameter int NUM_THR = 3,
  localparam int EV_W   = 2 * NUM_THR
) (
  input  logic                        valid_i,
  input  logic [CODE_W-1:0]           code_prev_i,
  input  logic [CODE_W-1:0]           code_new_i,
  input  logic [NUM_THR*CODE_W-1:0]   thr_flat_i,
  output logic [EV_W-1:0]             ev_o
);
  // Per threshold: rising event in low half, falling event in high half.
  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    logic [CODE_W-1:0] thr;
    logic              prev_hi;
    logic              new_hi;
    assign thr     = thr_flat_i[i*CODE_W +: CODE_W];
    assign prev_hi = (code_prev_i >= thr);
    assign new_hi  = (code_new_i >= thr);
    assign ev_o[i]         = valid_i && !prev_hi && new_hi;
    assign ev_o[NUM_THR+i] = valid_i && prev_hi && !new_hi;
  end
endmodule

// File: rtl/tsa_regfile.sv
module tsa_regfile
  import tsa_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int NUM_THR = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int EV_W   = 2 * NUM_THR
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      code_vld_i,
  input  logic [CODE_W-1:0]         code_i,
  input  logic [EV_W-1:0]           ev_raw_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic [NUM_THR*CODE_W-1:0] thr_flat_o,
  output logic [CODE_W-1:0]         code_q_o,
  output logic [EV_W-1:0]           status_o,
  output logic [EV_W-1:0]           mask_o
);
  logic [EV_W-1:0]   status_q, status_d;
  logic [EV_W-1:0]   mask_q, enable_q, ctrl_q;
  logic [CODE_W-1:0] code_q;
  logic [EV_W-1:0]   ev_en;
  logic              sel_status, sel_mask, sel_ctrl, sel_enable;
  logic              status_we;
  logic [NUM_THR-1:0] sel_thr;

  assign sel_status = we_i && (addr_i == ADDR_W'(OFS_STATUS));
  assign sel_mask   = we_i && (addr_i == ADDR_W'(OFS_MASK));
  assign sel_ctrl   = we_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_enable = we_i && (addr_i == ADDR_W'(OFS_ENABLE));

  // Next-state for status: clear by written zeros, then new events win.
  assign ev_en = ev_raw_i & enable_q;
  always_comb begin
    status_d = status_q;
    if (sel_status) status_d = status_q & wdata_i[EV_W-1:0];
    status_d  = status_d | ev_en;
    status_we = sel_status || (|ev_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      enable_q <= '0;
      ctrl_q   <= '0;
      code_q   <= '0;
    end else begin
      if (status_we)  status_q <= status_d;
      if (sel_mask)   mask_q   <= wdata_i[EV_W-1:0];
      if (sel_enable) enable_q <= wdata_i[EV_W-1:0];
      if (sel_ctrl)   ctrl_q   <= wdata_i[EV_W-1:0];
      if (code_vld_i) code_q   <= code_i;
    end
  end

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr_reg
    logic [CODE_W-1:0] thr_q;
    assign sel_thr[i] = we_i && (addr_i == ADDR_W'(thr_ofs(i)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          thr_q <= '0;
      else if (sel_thr[i]) thr_q <= wdata_i[CODE_W-1:0];
    end
    assign thr_flat_o[i*CODE_W +: CODE_W] = thr_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFS_STATUS)) rdata_o = DATA_W'(status_q);
    if (addr_i == ADDR_W'(OFS_MASK))   rdata_o = DATA_W'(mask_q);
    if (addr_i == ADDR_W'(OFS_CTRL))   rdata_o = DATA_W'(ctrl_q);
    if (addr_i == ADDR_W'(OFS_ENABLE)) rdata_o = DATA_W'(enable_q);
    if (addr_i == ADDR_W'(OFS_CODE))   rdata_o = DATA_W'(code_q);
    for (int i = 0; i < NUM_THR; i++) begin
      if (addr_i == ADDR_W'(thr_ofs(i)))
        rdata_o = DATA_W'(thr_flat_o[i*CODE_W +: CODE_W]);
    end
  end

  assign code_q_o = code_q;
  assign status_o = status_q;
  assign mask_o   = mask_q;

  // R3: strobed code is captured at the sampling edge
  a_r3_code_capture: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_i |=> (code_q == $past(code_i)));

  // R6: without a strobe or a status write, status does not move
  a_r6_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_vld_i && !sel_status) |=> $stable(status_q));

  // R7: a newly set status bit always had its enable bit set
  a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));

  // R9: writing zero with no event arriving empties status
  a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_status && (wdata_i[EV_W-1:0] == '0) && (ev_raw_i == '0)) |=> (status_q == '0));

  // R10: every enabled event is pending afterwards, clearing write or not
  a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_en) |=> ((status_q & $past(ev_en)) == $past(ev_en)));
endmodule

// File: rtl/tsa_irq_gate.sv
module tsa_irq_gate #(
  parameter int EV_W = 6
) (
  input  logic [EV_W-1:0] status_i,
  input  logic [EV_W-1:0] mask_i,
  output logic            irq_o
);
  assign irq_o = |(status_i & mask_i);
endmodule

// File: rtl/tsense_alarm_ctrl.sv
module tsense_alarm_ctrl #(
  parameter int CODE_W  = 12,
  parameter int NUM_THR = 3,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  localparam int EV_W   = 2 * NUM_THR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              code_vld_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              irq_o
);
  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic [NUM_THR*CODE_W-1:0] thr_flat;
  logic [CODE_W-1:0]         code_q;
  logic [EV_W-1:0]           ev_raw, status, mask;

  // Asserted asynchronously, released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tsa_cross_detect #(.CODE_W(CODE_W), .NUM_THR(NUM_THR)) u_detect (
    .valid_i     (code_vld_i),
    .code_prev_i (code_q),
    .code_new_i  (code_i),
    .thr_flat_i  (thr_flat),
    .ev_o        (ev_raw)
  );

  tsa_regfile #(.CODE_W(CODE_W), .NUM_THR(NUM_THR), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .code_vld_i (code_vld_i),
    .code_i     (code_i),
    .ev_raw_i   (ev_raw),
    .rdata_o    (reg_rdata_o),
    .thr_flat_o (thr_flat),
    .code_q_o   (code_q),
    .status_o   (status),
    .mask_o     (mask)
  );

  tsa_irq_gate #(.EV_W(EV_W)) u_irq (
    .status_i (status),
    .mask_i   (mask),
    .irq_o    (irq_o)
  );
endmodule

// File: tb/test_tsense_alarm_ctrl.sv
module test_tsense_alarm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        vld = 1'b0;
  logic [11:0] code = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_ST = 8'h04, A_MK = 8'h08, A_CT = 8'h0C, A_EN = 8'h10;
  localparam logic [7:0] A_T1 = 8'h14, A_T2 = 8'h18, A_T3 = 8'h1C, A_CD = 8'h28;

  always #2 clk = ~clk;

  tsense_alarm_ctrl i_tsense_alarm_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .code_vld_i(vld),
    .code_i(code), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic sample(input logic [11:0] v);
    @(negedge clk);
    code = v; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 status", A_ST, 0); rd_chk("R1 mask", A_MK, 0);
    rd_chk("R1 ctrl", A_CT, 0);   rd_chk("R1 enable", A_EN, 0);
    rd_chk("R1 thr1", A_T1, 0);   rd_chk("R1 thr2", A_T2, 0);
    rd_chk("R1 thr3", A_T3, 0);   rd_chk("R1 code", A_CD, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_regmap;
    wr(A_T1, 32'hFFFF_F100); rd_chk("R2 thr1 width", A_T1, 32'h100);
    wr(A_MK, 32'hFFFF_FFFF); rd_chk("R2 mask width", A_MK, 32'h3F);
    wr(A_CT, 32'h0000_00FF); rd_chk("R2 ctrl width", A_CT, 32'h3F);
    rd_chk("R2 unmapped 0x00", 8'h00, 0);
    rd_chk("R2 unmapped 0x24", 8'h24, 0);
    wr(A_MK, 0); wr(A_CT, 0);
    wr(A_T2, 32'h200); wr(A_T3, 32'h300); wr(A_EN, 32'h3F);
    rd_chk("R2 thr2", A_T2, 32'h200); rd_chk("R2 thr3", A_T3, 32'h300);
    rd_chk("R2 enable", A_EN, 32'h3F);
  endtask

  task automatic t_code;
    sample(12'h050);
    rd_chk("R3 code capture", A_CD, 32'h050);
    rd_chk("R6 below all", A_ST, 0);
    @(negedge clk); code = 12'hABC;
    repeat (3) @(negedge clk);
    rd_chk("R3 code hold", A_CD, 32'h050);
    rd_chk("R6 no strobe no event", A_ST, 0);
  endtask

  task automatic t_rise_mask;
    sample(12'h100);
    rd_chk("R4 rise at equal", A_ST, 32'h01);
    chk("R8 masked irq low", 32'(irq), 0);
    wr(A_MK, 32'h01); #1 chk("R8 unmasked irq high", 32'(irq), 1);
    wr(A_MK, 32'h02); #1 chk("R8 other mask irq low", 32'(irq), 0);
    wr(A_MK, 32'h3F); #1 chk("R8 all mask irq high", 32'(irq), 1);
    wr(A_ST, 0);
    rd_chk("R9 zero clears", A_ST, 0);
    chk("R9 irq after clear", 32'(irq), 0);
    sample(12'h150);
    rd_chk("R6 stays above", A_ST, 0);
  endtask

  task automatic t_fall;
    sample(12'h0FF);
    rd_chk("R5 fall thr1", A_ST, 32'h08);
    wr(A_ST, 32'h3F);
    rd_chk("R9 write ones keeps no set", A_ST, 32'h08);
    wr(A_ST, 0);
  endtask

  task automatic t_multi;
    sample(12'h350);
    rd_chk("R11 rise three", A_ST, 32'h07);
    wr(A_ST, 32'h02);
    rd_chk("R9 partial clear", A_ST, 32'h02);
    wr(A_ST, 0);
    sample(12'h000);
    rd_chk("R11 fall three", A_ST, 32'h38);
    wr(A_ST, 0);
  endtask

  task automatic t_enable;
    wr(A_EN, 32'h3D);
    sample(12'h250);
    rd_chk("R7 disabled event dropped", A_ST, 32'h01);
    wr(A_EN, 32'h3F);
  endtask

  task automatic t_prio;
    // status holds 0x01; clear and falling crossing of thr1, thr2 together
    @(negedge clk);
    addr = A_ST; wdata = 0; we = 1'b1; code = 12'h050; vld = 1'b1;
    @(negedge clk);
    we = 1'b0; vld = 1'b0;
    rd_chk("R10 event beats clear", A_ST, 32'h18);
    wr(A_ST, 0);
  endtask

  task automatic t_timing;
    @(negedge clk);
    addr = A_ST; code = 12'h150; vld = 1'b1;
    #1;
    chk("R12 status before edge", rdata, 0);
    chk("R12 irq before edge", 32'(irq), 0);
    @(negedge clk);
    vld = 1'b0;
    #1;
    chk("R12 status after edge", rdata, 32'h01);
    chk("R12 irq after edge", 32'(irq), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_regmap;
    t_code;
    t_rise_mask;
    t_fall;
    t_multi;
    t_enable;
    t_prio;
    t_timing;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule